// File: doc/BRIEF.md
# Dual 16/32-bit Interval Timer

The block holds two counting halves, A and B. In split configuration each half is a separate 16-bit timer, and each has its own 8-bit clock divider. In fused configuration the two halves form one 32-bit counter with no divider. Only the A-side settings steer it: its mode, its direction, its enable and its status bit. B is the upper half and its own settings are left unused.

Each timer runs once and stops (one-shot), or restarts itself each time it expires (periodic). It counts either towards zero or up to its interval value. It can also be armed so that enabling it waits for a trigger pin before any counting starts. Software sets everything through a plain word-wide write port with an address. A combinational read port returns the settings, the live counter values and the sticky expiry flags. Each timer also drives a one-cycle expiry pulse and a level flag that stays up until it is cleared.

Top module: `dual_timer`

## Requirements
- R1: After reset, the configuration register (address 0) reads 0 (fused). Both mode words (addresses 1 and 2) read 0. The control word (address 3) reads 0. Both divider values (addresses 6 and 7) read 0. The status word (address 8) reads 0, and both pulses are low. Both halves and both interval values are all ones, so in fused configuration address 9 and address 4 read 0xFFFFFFFF and address 10 reads 0x0000FFFF.
- R2: Writing 1 to a timer's enable bit starts the timer. Bit 0 of address 3 enables A and bit 1 enables B. A down-counting timer loads its interval value in the cycle of the write. It then falls by one per count step, and it expires on the step taken while it holds zero, which is load+1 steps after the start. A one-shot timer then holds zero and clears its own enable bit. Mode word bits are: bit 0 selects periodic (1) or one-shot (0), bit 1 selects up (1) or down (0), and bit 2 selects wait-for-trigger.
- R3: An up-counting timer starts from zero and rises by one per step. It expires on the step taken while it equals its interval value. A periodic timer then reloads its start value (zero when counting up, the interval when counting down) and keeps its enable bit set.
- R4: In split configuration the count step comes once every pre+1 clocks. Here pre is the 8-bit divider value for that half, at address 6 for A and address 7 for B, and the first step comes pre+1 clocks after the start.
- R5: Any configuration value other than 4 fuses the halves into one 32-bit counter, with carry and borrow passed from the low half to the high half. The address 4 interval write then sets all 32 bits. The divider, B's mode word, B's enable bit and writes to address 5 all have no effect, and status bit 1 never sets.
- R6: With wait-for-trigger set, enabling the timer loads the start value but does not count. Counting begins on the clock after the half's trigger input is seen high, and the trigger is ignored while the timer is not armed.
- R7: An expiry sets the timer's status bit (bit 0 for A, bit 1 for B at address 8) and its level output, and raises its pulse output for one cycle, all on the same clock edge. A status bit stays set until a write to address 8 has a 1 in that bit position. A 0 in a bit position leaves that bit unchanged.
- R8: In split configuration (value 4 at address 0), A and B keep their own mode, direction, interval and divider, and they run at the same time without affecting each other.
- R9: Writing 0 to a running timer's enable bit freezes its counter at once. Writing 1 again reloads the start value.
- R10: Address 9 reads A's live count, or the full 32-bit count when fused. Address 10 reads B's live count. Address 4 reads A's interval, or all 32 bits when fused, and address 5 reads B's interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Write address |
| wr_data | input | 2*HALF_W (32) | Write data |
| rd_addr | input | ADDR_W (4) | Read address |
| rd_data | output | 2*HALF_W (32) | Combinational read data |
| trig_a | input | 1 | Start trigger for timer A |
| trig_b | input | 1 | Start trigger for timer B |
| tmo_pulse | output | 2 | One-cycle expiry pulse, bit 0 = A, bit 1 = B |
| tmo_flag | output | 2 | Sticky expiry flags, same bit order |

## Verification
Take the clock edge that captures the enabling write as edge k. A down-counting timer then reads load-j after edge k+j. Its pulse and flag rise after edge k+(load+1)(pre+1), and an up-counting timer follows the same rule. A triggered start moves that origin to the edge that samples the trigger. Reads are combinational, so every check is taken at the falling edge just after the edge on which the value is due. The checks also look one cycle before and one cycle after each expiry, which catches a result that lands early, late, or is held for more than one cycle.

// File: rtl/dt_pkg.sv
package dt_pkg;
  // register addresses
  localparam int DT_A_CFG   = 0;
  localparam int DT_A_MODEA = 1;
  localparam int DT_A_MODEB = 2;
  localparam int DT_A_CTL   = 3;
  localparam int DT_A_LOADA = 4;
  localparam int DT_A_LOADB = 5;
  localparam int DT_A_PREA  = 6;
  localparam int DT_A_PREB  = 7;
  localparam int DT_A_STAT  = 8;
  localparam int DT_A_VALA  = 9;
  localparam int DT_A_VALB  = 10;

  localparam logic [2:0] DT_SPLIT_CODE = 3'd4;

  typedef struct packed {
    logic wot;       // bit 2: wait for trigger
    logic up;        // bit 1: count up
    logic periodic;  // bit 0: periodic
  } dt_mode_t;
endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  logic [PRE_W-1:0] pc_q;

  assign tick = run && (pc_q >= pre);

  always_ff @(posedge clk) begin
    if (!rst_n)      pc_q <= '0;
    else if (clr)    pc_q <= '0;
    else if (run)    pc_q <= tick ? '0 : pc_q + 1'b1;
  end

  // R4
  tick_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pc_q == '0));
endmodule

// File: rtl/dt_chan.sv
module dt_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic kill,
  input  logic wot,
  input  logic trig,
  output logic run
);
  logic armed_q, run_q;

  assign run = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (kill) begin
      run_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (start) begin
      run_q   <= !wot;
      armed_q <= wot;
    end else if (armed_q && trig) begin
      run_q   <= 1'b1;
      armed_q <= 1'b0;
    end
  end

  // R6
  wot_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wot && !kill) |=> (!run_q && armed_q));

  // R6
  trig_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && trig && !kill && !start) |=> run_q);
endmodule

// File: rtl/dt_half.sv
module dt_half #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         step,
  input  logic         wrap,
  input  logic         up,
  input  logic         periodic,
  input  logic [W-1:0] load,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] init_val;

  assign cnt      = cnt_q;
  assign init_val = up ? '0 : load;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '1;
    else if (start)              cnt_q <= init_val;
    else if (wrap) begin
      if (periodic)              cnt_q <= init_val;
    end
    else if (step)               cnt_q <= up ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  // R2
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && !wrap && !up) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && !wrap && up) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int HALF_W = 16,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [2*HALF_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [2*HALF_W-1:0]   rd_data,
  input  logic                  trig_a,
  input  logic                  trig_b,
  output logic [1:0]            tmo_pulse,
  output logic [1:0]            tmo_flag
);
  import dt_pkg::*;

  localparam int DW = 2 * HALF_W;

  logic [2:0]        cfg_q;
  dt_mode_t          mode_a_q, mode_b_q, mode_b_eff;
  logic [1:0]        en_q;
  logic [HALF_W-1:0] load_a_q, load_b_q;
  logic [PRE_W-1:0]  pre_a_q, pre_b_q;
  logic [1:0]        flag_q, pulse_q;
  logic              split;

  logic wr_cfg, wr_ma, wr_mb, wr_ctl, wr_la, wr_lb, wr_pa, wr_pb, wr_st;

  logic [HALF_W-1:0] cnt_a, cnt_b;
  logic run_a, run_b, tick_a, tick_pb, tick_b;
  logic start_a, start_b, kill_a, kill_b;
  logic lo_hit, hi_hit, term_a, term_b, carry;
  logic ev_a, ev_b, os_a, os_b;
  logic start_hb, step_hb, wrap_hb;

  assign split      = (cfg_q == DT_SPLIT_CODE);
  assign mode_b_eff = split ? mode_b_q : mode_a_q;

  // write decode
  assign wr_cfg = wr_en && (wr_addr == ADDR_W'(DT_A_CFG));
  assign wr_ma  = wr_en && (wr_addr == ADDR_W'(DT_A_MODEA));
  assign wr_mb  = wr_en && (wr_addr == ADDR_W'(DT_A_MODEB));
  assign wr_ctl = wr_en && (wr_addr == ADDR_W'(DT_A_CTL));
  assign wr_la  = wr_en && (wr_addr == ADDR_W'(DT_A_LOADA));
  assign wr_lb  = wr_en && (wr_addr == ADDR_W'(DT_A_LOADB));
  assign wr_pa  = wr_en && (wr_addr == ADDR_W'(DT_A_PREA));
  assign wr_pb  = wr_en && (wr_addr == ADDR_W'(DT_A_PREB));
  assign wr_st  = wr_en && (wr_addr == ADDR_W'(DT_A_STAT));

  // start / stop
  assign start_a = wr_ctl && wr_data[0] && !en_q[0];
  assign start_b = wr_ctl && wr_data[1] && !en_q[1] && split;

  // terminal detection, fused when not split
  assign lo_hit = mode_a_q.up ? (cnt_a == load_a_q) : (cnt_a == '0);
  assign hi_hit = mode_b_eff.up ? (cnt_b == load_b_q) : (cnt_b == '0);
  assign term_a = lo_hit && (split || hi_hit);
  assign term_b = hi_hit;
  assign carry  = mode_a_q.up ? (&cnt_a) : (cnt_a == '0);

  assign tick_b = split ? tick_pb : tick_a;
  assign ev_a   = tick_a && term_a;
  assign ev_b   = split && tick_pb && term_b;
  assign os_a   = ev_a && !mode_a_q.periodic;
  assign os_b   = ev_b && !mode_b_q.periodic;
  assign kill_a = (wr_ctl && !wr_data[0]) || os_a;
  assign kill_b = (wr_ctl && !wr_data[1]) || os_b || !split;

  // upper half steering
  assign start_hb = split ? start_b : start_a;
  assign step_hb  = split ? tick_b  : (tick_a && carry);
  assign wrap_hb  = split ? ev_b    : ev_a;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      mode_a_q <= '0;
      mode_b_q <= '0;
      load_a_q <= '1;
      load_b_q <= '1;
      pre_a_q  <= '0;
      pre_b_q  <= '0;
    end else begin
      if (wr_cfg) cfg_q    <= wr_data[2:0];
      if (wr_ma)  mode_a_q <= dt_mode_t'(wr_data[2:0]);
      if (wr_mb)  mode_b_q <= dt_mode_t'(wr_data[2:0]);
      if (wr_pa)  pre_a_q  <= wr_data[PRE_W-1:0];
      if (wr_pb)  pre_b_q  <= wr_data[PRE_W-1:0];
      if (wr_la) begin
        load_a_q <= wr_data[HALF_W-1:0];
        if (!split) load_b_q <= wr_data[DW-1:HALF_W];
      end
      if (wr_lb && split) load_b_q <= wr_data[HALF_W-1:0];
    end
  end

  // enable bits, a one-shot expiry wins over a write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      if (wr_ctl)          en_q[0] <= wr_data[0];
      if (os_a)            en_q[0] <= 1'b0;
      if (wr_ctl && split) en_q[1] <= wr_data[1];
      if (os_b || !split)  en_q[1] <= 1'b0;
    end
  end

  // status: set has priority over clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= '0;
      pulse_q <= '0;
    end else begin
      flag_q  <= (flag_q & ~(wr_st ? wr_data[1:0] : 2'b00)) | {ev_b, ev_a};
      pulse_q <= {ev_b, ev_a};
    end
  end

  assign tmo_pulse = pulse_q;
  assign tmo_flag  = flag_q;

  dt_chan u_chan_a (
    .clk(clk), .rst_n(rst_n), .start(start_a), .kill(kill_a),
    .wot(mode_a_q.wot), .trig(trig_a), .run(run_a)
  );

  dt_chan u_chan_b (
    .clk(clk), .rst_n(rst_n), .start(start_b), .kill(kill_b),
    .wot(mode_b_q.wot), .trig(trig_b), .run(run_b)
  );

  dt_prescaler #(.PRE_W(PRE_W)) u_pre_a (
    .clk(clk), .rst_n(rst_n), .clr(start_a), .run(run_a),
    .pre(split ? pre_a_q : '0), .tick(tick_a)
  );

  dt_prescaler #(.PRE_W(PRE_W)) u_pre_b (
    .clk(clk), .rst_n(rst_n), .clr(start_b), .run(run_b),
    .pre(pre_b_q), .tick(tick_pb)
  );

  dt_half #(.W(HALF_W)) u_half_a (
    .clk(clk), .rst_n(rst_n), .start(start_a), .step(tick_a), .wrap(ev_a),
    .up(mode_a_q.up), .periodic(mode_a_q.periodic), .load(load_a_q), .cnt(cnt_a)
  );

  dt_half #(.W(HALF_W)) u_half_b (
    .clk(clk), .rst_n(rst_n), .start(start_hb), .step(step_hb), .wrap(wrap_hb),
    .up(mode_b_eff.up), .periodic(mode_b_eff.periodic), .load(load_b_q), .cnt(cnt_b)
  );

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(DT_A_CFG):   rd_data = DW'(cfg_q);
      ADDR_W'(DT_A_MODEA): rd_data = DW'(mode_a_q);
      ADDR_W'(DT_A_MODEB): rd_data = DW'(mode_b_q);
      ADDR_W'(DT_A_CTL):   rd_data = DW'(en_q);
      ADDR_W'(DT_A_LOADA): rd_data = split ? DW'(load_a_q) : {load_b_q, load_a_q};
      ADDR_W'(DT_A_LOADB): rd_data = DW'(load_b_q);
      ADDR_W'(DT_A_PREA):  rd_data = DW'(pre_a_q);
      ADDR_W'(DT_A_PREB):  rd_data = DW'(pre_b_q);
      ADDR_W'(DT_A_STAT):  rd_data = DW'(flag_q);
      ADDR_W'(DT_A_VALA):  rd_data = split ? DW'(cnt_a) : {cnt_b, cnt_a};
      ADDR_W'(DT_A_VALB):  rd_data = DW'(cnt_b);
      default:             rd_data = '0;
    endcase
  end

  // R2
  oneshot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    os_a |=> (!en_q[0] && !run_a));

  // R3
  periodic_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_a && mode_a_q.periodic && !wr_ctl) |=> (en_q[0] && run_a));

  // R7
  flag_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_a |=> (tmo_flag[0] && tmo_pulse[0]));

  // R7
  flag_b_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_b |=> (tmo_flag[1] && tmo_pulse[1]));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag[0] && !wr_st) |=> tmo_flag[0]);

  // R5
  fused_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !split |=> (!run_b && !tmo_pulse[1]));
endmodule

// File: tb/dual_timer_tb.sv
module dual_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        trig_a = 1'b0;
  logic        trig_b = 1'b0;
  logic [1:0]  tmo_pulse, tmo_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dual_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .trig_a(trig_a), .trig_b(trig_b),
    .tmo_pulse(tmo_pulse), .tmo_flag(tmo_flag)
  );

  localparam logic [3:0] CFG = 0, MA = 1, MB = 2, CTL = 3, LA = 4, LB = 5,
                         PA = 6, PB = 7, ST = 8, VA = 9, VB = 10;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic idle_all;
    wr(CTL, 32'h0);
    wr(ST, 32'h3);
  endtask

  task automatic t_reset;
    chk_rd("R1 cfg", CFG, 32'h0);
    chk_rd("R1 modeA", MA, 32'h0);
    chk_rd("R1 modeB", MB, 32'h0);
    chk_rd("R1 ctl", CTL, 32'h0);
    chk_rd("R1 preA", PA, 32'h0);
    chk_rd("R1 preB", PB, 32'h0);
    chk_rd("R1 status", ST, 32'h0);
    chk_rd("R1 fused value", VA, 32'hFFFF_FFFF);
    chk_rd("R1 fused load", LA, 32'hFFFF_FFFF);
    chk_rd("R1 value B", VB, 32'h0000_FFFF);
    chk("R1 pulses", {30'h0, tmo_pulse}, 32'h0);
  endtask

  task automatic t_oneshot_down;
    wr(CFG, 32'h4);
    wr(MA, 32'h0);
    wr(PA, 32'h0);
    wr(LA, 32'h5);
    chk_rd("R10 split loadA", LA, 32'h5);
    wr(CTL, 32'h1);                 // edge k
    chk_rd("R2 start value", VA, 32'h5);
    cyc(3);
    chk_rd("R2 k+3", VA, 32'h2);
    cyc(2);
    chk_rd("R2 k+5", VA, 32'h0);
    chk("R2 no pulse yet", {30'h0, tmo_pulse}, 32'h0);
    cyc(1);
    chk("R2 pulse at k+6", {30'h0, tmo_pulse}, 32'h1);
    chk("R7 flag A set", {30'h0, tmo_flag}, 32'h1);
    chk_rd("R2 enable cleared", CTL, 32'h0);
    cyc(1);
    chk("R7 pulse one cycle", {30'h0, tmo_pulse}, 32'h0);
    cyc(3);
    chk_rd("R2 holds zero", VA, 32'h0);
    chk("R2 no second expiry", {30'h0, tmo_pulse}, 32'h0);
  endtask

  task automatic t_flag_clear;
    wr(ST, 32'h2);
    chk_rd("R7 zero bit keeps flag", ST, 32'h1);
    wr(ST, 32'h1);
    chk_rd("R7 one clears flag", ST, 32'h0);
    chk("R7 level output cleared", {30'h0, tmo_flag}, 32'h0);
  endtask

  task automatic t_pair;
    wr(MA, 32'h1);                  // periodic down
    wr(LA, 32'h4);
    wr(MB, 32'h3);                  // periodic up
    wr(LB, 32'h3);
    wr(PB, 32'h2);
    wr(CTL, 32'h3);                 // edge k
    chk_rd("R3 up starts at zero", VB, 32'h0);
    cyc(3);
    chk_rd("R4 first step at k+3", VB, 32'h1);
    cyc(2);
    chk("R8 A expires at k+5", {30'h0, tmo_pulse}, 32'h1);
    chk_rd("R3 A reloads", VA, 32'h4);
    chk_rd("R4 B between steps", VB, 32'h1);
    cyc(2);
    chk_rd("R8 A k+7", VA, 32'h2);
    cyc(4);
    chk_rd("R3 B at interval", VB, 32'h3);
    chk("R4 B no pulse k+11", {31'h0, tmo_pulse[1]}, 32'h0);
    cyc(1);
    chk("R4 B expires at k+12", {31'h0, tmo_pulse[1]}, 32'h1);
    chk_rd("R3 B wraps to zero", VB, 32'h0);
    chk_rd("R7 both flags", ST, 32'h3);
    chk_rd("R3 enables kept", CTL, 32'h3);
    idle_all();
  endtask

  task automatic t_trigger;
    wr(MA, 32'h4);                  // wait, down, one-shot
    wr(LA, 32'h3);
    trig_a = 1'b1;                  // ignored while not armed
    cyc(2);
    trig_a = 1'b0;
    wr(CTL, 32'h1);                 // edge k
    cyc(5);
    chk_rd("R6 held while armed", VA, 32'h3);
    trig_a = 1'b1;
    cyc(1);                         // edge t
    trig_a = 1'b0;
    chk_rd("R6 no step on trigger edge", VA, 32'h3);
    cyc(1);
    chk_rd("R6 steps after trigger", VA, 32'h2);
    cyc(3);
    chk("R6 expiry at t+4", {30'h0, tmo_pulse}, 32'h1);
    idle_all();
  endtask

  task automatic t_stop;
    wr(MA, 32'h1);
    wr(LA, 32'd100);
    wr(CTL, 32'h1);                 // edge k
    cyc(10);
    chk_rd("R9 running", VA, 32'd90);
    wr(CTL, 32'h0);                 // edge k+11
    cyc(5);
    chk_rd("R9 frozen", VA, 32'd89);
    wr(CTL, 32'h1);
    chk_rd("R9 restart reloads", VA, 32'd100);
    idle_all();
  endtask

  task automatic t_fused_down;
    wr(CFG, 32'h0);
    wr(PA, 32'h5);
    wr(MA, 32'h0);
    wr(MB, 32'h3);
    wr(LA, 32'h0001_0002);
    wr(LB, 32'h1234);
    chk_rd("R5 high load write ignored", LA, 32'h0001_0002);
    wr(CTL, 32'h3);                 // edge k
    cyc(2);
    chk_rd("R5 fused k+2", VA, 32'h0001_0000);
    cyc(1);
    chk_rd("R5 borrow k+3", VA, 32'h0000_FFFF);
    cyc(65535);
    chk_rd("R5 zero at k+65538", VA, 32'h0);
    chk("R5 no pulse k+65538", {30'h0, tmo_pulse}, 32'h0);
    cyc(1);
    chk("R5 pulse at k+65539", {30'h0, tmo_pulse}, 32'h1);
    chk_rd("R5 status bit 1 idle", ST, 32'h1);
    chk_rd("R5 one-shot clears", CTL, 32'h0);
    idle_all();
  endtask

  task automatic t_fused_up;
    wr(MA, 32'h3);                  // periodic up
    wr(LA, 32'h0001_0001);
    wr(CTL, 32'h1);                 // edge k
    cyc(32'h10000);
    chk_rd("R5 carry at k+65536", VA, 32'h0001_0000);
    cyc(1);
    chk_rd("R5 at interval", VA, 32'h0001_0001);
    chk("R5 no pulse before", {30'h0, tmo_pulse}, 32'h0);
    cyc(1);
    chk("R5 up expiry", {30'h0, tmo_pulse}, 32'h1);
    chk_rd("R5 up wraps", VA, 32'h0);
    idle_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_oneshot_down();
    t_flag_clear();
    t_pair();
    t_trigger();
    t_stop();
    t_fused_down();
    t_fused_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule